// File: doc/BRIEF.md
# Receive Packet Buffer with Per-Packet Status Queue

This block holds received frames between the wire side and the host. The wire side opens a frame, writes its bytes one per cycle and closes it with a four-bit error code. The bytes go into a circular byte store. Each frame also gets an entry in a small status queue. That entry records how many bytes were kept, whether the frame has been closed, and its error code. Status is kept per frame, not per byte. The host always sees a 16-bit status word for the oldest frame. It pops that frame's bytes one at a time, and it removes the frame with a discard command once it is done with it.

Four diagnostic flags report what the block is doing:
- a frame is being written in;
- the byte store has filled (overrun);
- the status queue is full (status overrun);
- the host read past the end of a frame (underrun).

The two full conditions stop reception and clear themselves once room returns. An underrun is fatal: it drives the adapter failure output and stays set until a receive reset. The command input takes five-bit opcodes. Opcode 5 is receive reset and opcode 8 is discard-oldest-frame. The asynchronous reset acts as the global reset.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After reset, and whenever no frame is queued, the status word is 16'h8000: bit 15 set, all other bits zero.
- R2: While the oldest frame is still open, bit 15 is 1, bits 14:11 are 0000, and bits 10:0 give the bytes written so far minus the bytes already read.
- R3: Once the oldest frame is closed, bit 15 is 0 and bits 10:0 give its unread byte count. Bits 14:11 carry the close code if it is one of 1000, 1001, 1011, 1100, 1101 or 0010; any other code is reported as 0000.
- R4: `rd_data` shows the next unread byte of the oldest frame. A pulse of `rd_req` consumes it and lowers the count in bits 10:0 by one. Bytes come out in the order they were written, across the wrap of the store.
- R5: A read with no unread byte in the oldest frame, or with no frame queued, consumes nothing. It sets `flag_underrun` and `adapter_fail`. Both stay set through discards and clear only on opcode 5 or `rst_n`.
- R6: Opcode 8 removes the oldest frame together with its unread bytes when that frame is closed. It is ignored if the queue is empty or the oldest frame is still open. Opcodes other than 5 and 8 have no effect.
- R7: A frame start while SLOTS (8) frames are queued sets `flag_stat_overrun`, and that frame is not stored. The flag clears when a frame is discarded.
- R8: A byte that arrives with the store full sets `flag_overrun`. That byte and the rest of its frame are dropped, and the frame closes with code 1000 and the count of bytes actually kept. While the flag is set, new frames keep no bytes. The flag clears once at least HYST (16) bytes are free.
- R9: `flag_receiving` rises in the cycle after an accepted frame start and falls in the cycle after its end. It stays low for a refused frame.
- R10: `rx_complete` is high exactly when a frame is queued and the oldest one is closed.
- R11: Opcode 5 empties the store and the queue and clears every flag in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| wr_start | input | 1 | Opens a new frame |
| wr_valid | input | 1 | `wr_data` holds a byte of the open frame |
| wr_data | input | 8 | Received byte |
| wr_end | input | 1 | Closes the open frame (may coincide with its last byte) |
| wr_err | input | 4 | Error code given with `wr_end` |
| rd_req | input | 1 | Host pops one byte of the oldest frame |
| rd_data | output | 8 | Next unread byte of the oldest frame |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 5 | Command opcode (5 receive reset, 8 discard) |
| rx_status | output | 16 | Status word of the oldest frame |
| rx_complete | output | 1 | Oldest frame is closed |
| flag_receiving | output | 1 | A frame is being written |
| flag_overrun | output | 1 | Byte store filled |
| flag_stat_overrun | output | 1 | Status queue full, frame refused |
| flag_underrun | output | 1 | Host read past the end of a frame |
| adapter_fail | output | 1 | Fatal error raised by underrun |

## Verification
The bench sends a single frame with no end and inspects it, which separates the open-frame status from the closed one and shows that a discard of an open head is refused. All sixteen close codes are swept to split the recognised error codes from the ones mapped to zero. Frame lengths from 1 to 20 bytes are sent into a 64-byte store; the byte patterns depend on both frame number and position, so a lost, repeated or misordered byte shows up, including across the wrap. Nine frames in a row test the queue limit, and oversized back-to-back frames fill the store. These two show the difference between a refused frame, which leaves no trace, and a truncated frame, which keeps its stored bytes and carries code 1000.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [3:0] ERR_NONE  = 4'b0000;
  localparam logic [3:0] ERR_OVR   = 4'b1000;
  localparam logic [3:0] ERR_BIG   = 4'b1001;
  localparam logic [3:0] ERR_RUNT  = 4'b1011;
  localparam logic [3:0] ERR_ALIGN = 4'b1100;
  localparam logic [3:0] ERR_CRC   = 4'b1101;
  localparam logic [3:0] ERR_DRIB  = 4'b0010;

  localparam logic [4:0] OP_RX_RESET = 5'd5;
  localparam logic [4:0] OP_DISCARD  = 5'd8;

  // Keep recognised codes, fold everything else to "no error".
  function automatic logic [3:0] norm_code(input logic [3:0] c);
    case (c)
      ERR_OVR, ERR_BIG, ERR_RUNT, ERR_ALIGN, ERR_CRC, ERR_DRIB: norm_code = c;
      default: norm_code = ERR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rxq_byte_store.sv
module rxq_byte_store #(
  parameter  int DEPTH = 2048,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  input  logic          skip,
  input  logic [AW:0]   skip_n,
  output logic [7:0]    head_data,
  output logic [AW:0]   free_n
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_nxt, rp_nxt;
  logic [AW:0]   used, used_nxt, adv;

  always_comb begin
    adv      = pop ? (AW+1)'(1) : (skip ? skip_n : '0);
    wp_nxt   = wp;
    rp_nxt   = rp;
    used_nxt = used;
    if (clr) begin
      wp_nxt   = '0;
      rp_nxt   = '0;
      used_nxt = '0;
    end else begin
      if (push) wp_nxt = wp + AW'(1);
      rp_nxt   = rp + adv[AW-1:0];
      used_nxt = used + (AW+1)'(push) - adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else begin
      wp   <= wp_nxt;
      rp   <= rp_nxt;
      used <= used_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= push_data;
  end

  assign head_data = mem[rp];
  assign free_n    = (AW+1)'(DEPTH) - used;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> used < (AW+1)'(DEPTH));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop || skip) |-> used >= adv);
endmodule

// File: rtl/rxq_status_queue.sv
module rxq_status_queue #(
  parameter  int SLOTS = 8,
  parameter  int CW    = 11,
  localparam int IW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          open,
  input  logic          bump,
  input  logic          close,
  input  logic [3:0]    close_code,
  input  logic          drop,
  output logic [IW:0]   q_cnt,
  output logic [CW-1:0] head_cnt,
  output logic          head_done,
  output logic [3:0]    head_code
);
  logic [CW-1:0] cnt  [SLOTS];
  logic [3:0]    code [SLOTS];
  logic [SLOTS-1:0] done, open_hit, wr_hit;
  logic [IW-1:0] hd, tl, wi, hd_nxt, tl_nxt, wi_nxt;
  logic [IW:0]   qn_nxt;

  for (genvar g = 0; g < SLOTS; g++) begin : g_hit
    assign open_hit[g] = open && (tl == IW'(g));
    assign wr_hit[g]   = wi == IW'(g);
  end

  always_comb begin
    hd_nxt = hd;
    tl_nxt = tl;
    wi_nxt = wi;
    qn_nxt = q_cnt;
    if (clr) begin
      hd_nxt = '0;
      tl_nxt = '0;
      wi_nxt = '0;
      qn_nxt = '0;
    end else begin
      if (open) begin
        wi_nxt = tl;
        tl_nxt = tl + IW'(1);
      end
      if (drop) hd_nxt = hd + IW'(1);
      qn_nxt = q_cnt + (IW+1)'(open) - (IW+1)'(drop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd    <= '0;
      tl    <= '0;
      wi    <= '0;
      q_cnt <= '0;
    end else begin
      hd    <= hd_nxt;
      tl    <= tl_nxt;
      wi    <= wi_nxt;
      q_cnt <= qn_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        cnt[i]  <= '0;
        code[i] <= '0;
        done[i] <= 1'b0;
      end
    end else if (!clr) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (open_hit[i]) begin
          cnt[i]  <= '0;
          code[i] <= '0;
          done[i] <= 1'b0;
        end else if (wr_hit[i]) begin
          if (bump) cnt[i] <= cnt[i] + CW'(1);
          if (close) begin
            done[i] <= 1'b1;
            code[i] <= close_code;
          end
        end
      end
    end
  end

  assign head_cnt  = cnt[hd];
  assign head_done = done[hd] && (q_cnt != '0);
  assign head_code = code[hd];

  assert_slot_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (open && !clr) |-> q_cnt < (IW+1)'(SLOTS));
  assert_drop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !clr) |-> q_cnt != '0);
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rxq_pkg::*;
#(
  parameter  int DEPTH = 2048,
  parameter  int SLOTS = 8,
  parameter  int HYST  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int IW    = $clog2(SLOTS),
  localparam int CW    = 11,
  localparam int CNT_MAX = (1 << CW) - 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_start,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic        wr_end,
  input  logic [3:0]  wr_err,
  input  logic        rd_req,
  output logic [7:0]  rd_data,
  input  logic        cmd_valid,
  input  logic [4:0]  cmd_op,
  output logic [15:0] rx_status,
  output logic        rx_complete,
  output logic        flag_receiving,
  output logic        flag_overrun,
  output logic        flag_stat_overrun,
  output logic        flag_underrun,
  output logic        adapter_fail
);
  logic rcv, rcv_nxt, dropping, dropping_nxt, stopped, stopped_nxt;
  logic ovr, ovr_nxt, sovr, sovr_nxt, unr, unr_nxt;
  logic [CW-1:0] hd_rd, hd_rd_nxt, wr_cnt, wr_cnt_nxt, head_cnt, head_left;
  logic [IW:0]   q_cnt;
  logic [AW:0]   free_n;
  logic [3:0]    head_code, close_code;
  logic head_done, rx_rst, disc, rd_try, rd_ok, rd_bad;
  logic start_ok, start_full, byte_try, byte_ok, byte_drop, close;

  always_comb begin
    rx_rst     = cmd_valid && (cmd_op == OP_RX_RESET);
    disc       = cmd_valid && (cmd_op == OP_DISCARD) && head_done;
    head_left  = head_cnt - hd_rd;
    rd_try     = rd_req && !cmd_valid;
    rd_ok      = rd_try && (q_cnt != '0) && (head_left != '0);
    rd_bad     = rd_try && !rd_ok;
    start_ok   = wr_start && !rcv && !dropping && (q_cnt <  (IW+1)'(SLOTS));
    start_full = wr_start && !rcv && !dropping && (q_cnt == (IW+1)'(SLOTS));
    byte_try   = rcv && wr_valid;
    byte_ok    = byte_try && !stopped && !ovr && (free_n != '0) && (wr_cnt < CW'(CNT_MAX));
    byte_drop  = byte_try && !byte_ok;
    close      = rcv && wr_end;
    close_code = (stopped || byte_drop) ? ERR_OVR : norm_code(wr_err);

    rcv_nxt      = rx_rst ? 1'b0 : (close ? 1'b0 : (start_ok ? 1'b1 : rcv));
    dropping_nxt = rx_rst ? 1'b0 : (dropping && wr_end ? 1'b0 : (start_full ? 1'b1 : dropping));
    stopped_nxt  = (rx_rst || start_ok) ? 1'b0 : (byte_drop ? 1'b1 : stopped);
    wr_cnt_nxt   = start_ok ? '0 : (byte_ok ? wr_cnt + CW'(1) : wr_cnt);
    if (rx_rst)                          ovr_nxt = 1'b0;
    else if (byte_try && free_n == '0)   ovr_nxt = 1'b1;
    else if (free_n >= (AW+1)'(HYST))    ovr_nxt = 1'b0;
    else                                 ovr_nxt = ovr;
    sovr_nxt  = rx_rst ? 1'b0 : (start_full ? 1'b1 : (disc ? 1'b0 : sovr));
    unr_nxt   = rx_rst ? 1'b0 : (rd_bad ? 1'b1 : unr);
    hd_rd_nxt = (rx_rst || disc) ? '0 : (rd_ok ? hd_rd + CW'(1) : hd_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv      <= 1'b0;
      dropping <= 1'b0;
      stopped  <= 1'b0;
      ovr      <= 1'b0;
      sovr     <= 1'b0;
      unr      <= 1'b0;
      hd_rd    <= '0;
      wr_cnt   <= '0;
    end else begin
      rcv      <= rcv_nxt;
      dropping <= dropping_nxt;
      stopped  <= stopped_nxt;
      ovr      <= ovr_nxt;
      sovr     <= sovr_nxt;
      unr      <= unr_nxt;
      hd_rd    <= hd_rd_nxt;
      wr_cnt   <= wr_cnt_nxt;
    end
  end

  rxq_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_rst),
    .push(byte_ok && !rx_rst), .push_data(wr_data),
    .pop(rd_ok && !rx_rst), .skip(disc && !rx_rst), .skip_n((AW+1)'(head_left)),
    .head_data(rd_data), .free_n(free_n)
  );

  rxq_status_queue #(.SLOTS(SLOTS), .CW(CW)) u_queue (
    .clk(clk), .rst_n(rst_n), .clr(rx_rst),
    .open(start_ok), .bump(byte_ok), .close(close), .close_code(close_code),
    .drop(disc), .q_cnt(q_cnt), .head_cnt(head_cnt), .head_done(head_done),
    .head_code(head_code)
  );

  always_comb begin
    if (q_cnt == '0)     rx_status = 16'h8000;
    else if (!head_done) rx_status = {1'b1, 4'b0000, head_left};
    else                 rx_status = {1'b0, head_code, head_left};
  end

  assign rx_complete       = head_done;
  assign flag_receiving    = rcv;
  assign flag_overrun      = ovr;
  assign flag_stat_overrun = sovr;
  assign flag_underrun     = unr;
  assign adapter_fail      = unr;

  assert_underrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (unr && !(cmd_valid && cmd_op == OP_RX_RESET)) |=> unr);
  assert_rcv_drop_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rcv && dropping));
  assert_trunc_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (close && stopped) |-> close_code == ERR_OVR);
  assert_read_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |-> hd_rd < head_cnt);
endmodule

// File: tb/sim_rx_pkt_fifo.sv
module sim_rx_pkt_fifo;
  localparam int DEPTH = 64;
  localparam int SLOTS = 8;
  localparam int HYST  = 16;

  logic clk = 1'b0;
  logic rst_n, wr_start, wr_valid, wr_end, rd_req, cmd_valid;
  logic [7:0] wr_data, rd_data;
  logic [3:0] wr_err;
  logic [4:0] cmd_op;
  logic [15:0] rx_status;
  logic rx_complete, flag_receiving, flag_overrun, flag_stat_overrun, flag_underrun, adapter_fail;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  rx_pkt_fifo #(.DEPTH(DEPTH), .SLOTS(SLOTS), .HYST(HYST)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_end(wr_end), .wr_err(wr_err), .rd_req(rd_req), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .rx_status(rx_status), .rx_complete(rx_complete),
    .flag_receiving(flag_receiving), .flag_overrun(flag_overrun),
    .flag_stat_overrun(flag_stat_overrun), .flag_underrun(flag_underrun),
    .adapter_fail(adapter_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((p * 37 + i * 5 + 1) & 255);
  endfunction

  function automatic logic [3:0] norm(input logic [3:0] c);
    if (c == 4'b1000 || c == 4'b1001 || c == 4'b1011 || c == 4'b1100 ||
        c == 4'b1101 || c == 4'b0010) return c;
    return 4'b0000;
  endfunction

  task automatic send(input int p, input int len, input logic [3:0] code);
    wr_start = 1'b1;
    step;
    wr_start = 1'b0;
    if (len == 0) begin
      wr_end = 1'b1; wr_err = code;
      step;
    end
    for (int i = 0; i < len; i++) begin
      wr_valid = 1'b1; wr_data = pat(p, i);
      if (i == len - 1) begin wr_end = 1'b1; wr_err = code; end
      step;
    end
    wr_valid = 1'b0; wr_end = 1'b0; wr_err = 4'h0;
  endtask

  task automatic rd_byte(input string req, input int p, input int i);
    chk(req, 32'(rd_data), 32'(pat(p, i)));
    rd_req = 1'b1;
    step;
    rd_req = 1'b0;
  endtask

  task automatic cmd(input logic [4:0] op);
    cmd_valid = 1'b1; cmd_op = op;
    step;
    cmd_valid = 1'b0; cmd_op = 5'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_start = 0; wr_valid = 0; wr_end = 0; wr_err = 0; wr_data = 0;
    rd_req = 0; cmd_valid = 0; cmd_op = 0;
    step; step; step;
    rst_n = 1'b1;
    step;

    // R1 reset state
    chk("R1 status after reset", 32'(rx_status), 32'h8000);
    chk("R10 complete after reset", 32'(rx_complete), 0);
    chk("R1 flags after reset", 32'({flag_receiving, flag_overrun, flag_stat_overrun,
                                     flag_underrun, adapter_fail}), 0);

    // R9 / R2 / R6: open frame, discard refused, then close
    wr_start = 1'b1; step; wr_start = 1'b0;
    chk("R9 receiving after start", 32'(flag_receiving), 1);
    chk("R2 open empty frame", 32'(rx_status), 32'h8000);
    for (int i = 0; i < 3; i++) begin
      wr_valid = 1'b1; wr_data = pat(0, i); step;
    end
    wr_valid = 1'b0;
    chk("R2 open frame count", 32'(rx_status), 32'h8003);
    chk("R10 open head not complete", 32'(rx_complete), 0);
    cmd(5'd8);
    chk("R6 discard of open head ignored", 32'(rx_status), 32'h8003);
    cmd(5'd3);
    chk("R6 other opcode ignored", 32'(rx_status), 32'h8003);
    wr_end = 1'b1; wr_err = 4'b1101; step; wr_end = 1'b0; wr_err = 0;
    chk("R9 receiving after end", 32'(flag_receiving), 0);
    chk("R3 closed crc frame", 32'(rx_status), 32'h6803);
    chk("R10 closed head complete", 32'(rx_complete), 1);
    for (int i = 0; i < 3; i++) begin
      rd_byte("R4 byte of first frame", 0, i);
      chk("R4 count drops per read", 32'(rx_status), 32'({1'b0, 4'b1101, 11'(2 - i)}));
    end
    rd_req = 1'b1; step; rd_req = 1'b0;
    chk("R5 underrun on read past end", 32'(flag_underrun), 1);
    chk("R5 adapter fail on underrun", 32'(adapter_fail), 1);
    chk("R5 nothing consumed", 32'(rx_status), 32'h6800);
    cmd(5'd8);
    chk("R5 underrun survives discard", 32'(flag_underrun), 1);
    chk("R6 discard empties queue", 32'(rx_status), 32'h8000);
    cmd(5'd5);
    chk("R11 rx reset clears underrun", 32'({flag_underrun, adapter_fail}), 0);
    chk("R11 status after rx reset", 32'(rx_status), 32'h8000);

    // R3 sweep of every close code
    for (int c = 0; c < 16; c++) begin
      send(10 + c, 2 + c % 3, 4'(c));
      chk("R3 code normalisation", 32'(rx_status),
          32'({1'b0, norm(4'(c)), 11'(2 + c % 3)}));
      cmd(5'd8);
    end

    // R4 length sweep with content, across wraps of the 64-byte store
    for (int len = 1; len <= 20; len++) begin
      send(40 + len, len, 4'b0000);
      chk("R3 length reported", 32'(rx_status), 32'(len));
      for (int i = 0; i < len; i++) rd_byte("R4 content sweep", 40 + len, i);
      chk("R4 count zero after drain", 32'(rx_status), 0);
      cmd(5'd8);
    end
    chk("R10 empty queue not complete", 32'(rx_complete), 0);

    // R7 status queue limit
    cmd(5'd5);
    for (int p = 0; p < SLOTS; p++) send(100 + p, 3, 4'b0000);
    chk("R7 no status overrun at eight", 32'(flag_stat_overrun), 0);
    wr_start = 1'b1; step; wr_start = 1'b0;
    chk("R9 refused frame not receiving", 32'(flag_receiving), 0);
    chk("R7 status overrun on ninth", 32'(flag_stat_overrun), 1);
    for (int i = 0; i < 3; i++) begin
      wr_valid = 1'b1; wr_data = 8'hEE; wr_end = (i == 2); step;
    end
    wr_valid = 1'b0; wr_end = 1'b0;
    chk("R7 head unchanged", 32'(rx_status), 32'h0003);
    cmd(5'd8);
    chk("R7 flag clears on discard", 32'(flag_stat_overrun), 0);
    send(108, 4, 4'b0000);
    for (int k = 0; k < 7; k++) cmd(5'd8);
    chk("R7 refused frame left no entry", 32'(rx_status), 32'h0004);
    for (int i = 0; i < 4; i++) rd_byte("R7 refused frame left no bytes", 108, i);
    cmd(5'd8);

    // R8 byte store overrun
    cmd(5'd5);
    send(200, 40, 4'b0000);
    send(201, 40, 4'b0000);
    chk("R8 overrun flag set", 32'(flag_overrun), 1);
    send(202, 5, 4'b0000);
    chk("R8 head intact", 32'(rx_status), 32'h0028);
    cmd(5'd8);
    step;
    chk("R8 overrun clears with room", 32'(flag_overrun), 0);
    chk("R8 truncated frame code and count", 32'(rx_status), 32'h4018);
    for (int i = 0; i < 24; i++) rd_byte("R8 kept bytes", 201, i);
    cmd(5'd8);
    chk("R8 frame during overrun keeps nothing", 32'(rx_status), 32'h4000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule